// File: doc/BRIEF.md
# CRT Controller Host Register Bank

This block is the host-facing register file of a character-cell CRT controller. A host selects one of eighteen configuration registers through a 5-bit pointer. It then writes or reads that register through a data port. Each register keeps only the bits it implements. Each register has its own access rule: some can only be written, some can be written and read, and some can only be read. The timing generator receives every register value at all times on one flat bus.

The block also holds a small status byte. The status byte is read at the same address that loads the pointer. It reports three things:
- the device is present;
- a light-pen position has been captured;
- the beam is in blanking.

A rising edge on the light-pen strobe latches the display memory address into the two read-only position registers and sets the capture flag. The flag drops once the host has read both position registers through the data port.

Top module: `crtc_regbank`

## Requirements
- R1: A write on the select port loads the low 5 bits of `wdata` into the pointer. The pointer keeps its value until the next select write, so consecutive data writes all land in the same register.
- R2: A data write to registers 0 to 15 stores `wdata` masked to that register's implemented bits, and the unused bits read as zero. The implemented masks are: 0 to 3, 13 and 15 use 0xFF; 4, 6, 7 and 10 use 0x7F; 5, 9 and 11 use 0x1F; 8 uses 0x03; 12, 14 and 16 use 0x3F; 17 uses 0xFF.
- R3: A data write has no effect when the pointer is 16, 17 or any value from 18 to 31.
- R4: With `status_rd` low, `rdata` shows the selected register when the pointer is 12 to 17, and shows 0xFF for every other pointer value.
- R5: With `status_rd` high, `rdata` is the status byte:
  - bit 7 is always 1;
  - bit 6 is the light-pen capture flag;
  - bit 5 follows `blanking`;
  - bits 4:0 are zero.
- R6: On the first clock edge where `lpen_stb` is high after being low, register 16 takes `cur_addr[13:8]` and register 17 takes `cur_addr[7:0]`, and the capture flag sets. Holding the strobe high captures nothing further.
- R7: The capture flag clears on the clock edge at which the second of the two position registers (16 and 17, in either order) is read with a `data_rd` strobe. Reading only one of them, even repeatedly, leaves the flag set. A new capture restarts this tracking.
- R8: `cfg_bus[8*i+7:8*i]` always carries register i (0 to 17), with unused bits at zero.
- R9: A synchronous `rst` clears all registers, the pointer, the capture flag and the read tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_we | input | 1 | Select-port write strobe |
| data_we | input | 1 | Data-port write strobe |
| status_rd | input | 1 | Select-address read; routes the status byte to `rdata` |
| data_rd | input | 1 | Data-port read strobe; feeds capture-flag clearing |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| lpen_stb | input | 1 | Light-pen strobe from the timing logic |
| cur_addr | input | 14 | Current display memory address |
| blanking | input | 1 | High during blanking or flyback |
| cfg_bus | output | 144 | All eighteen registers, byte i = register i |

## Verification
The bench writes all ones through every writable register and checks each exported byte. A wrong mask would leak unused bits there. It also reads the write-only registers to confirm they return 0xFF rather than their stored value. Writes are aimed at 16, 17 and out-of-range pointers, where a design with loose write decoding would corrupt the light-pen latches or alias onto a low register. A select value with bit 5 set probes 5-bit truncation. The capture flag is exercised with one register read twice, with both orders of reading, and with a strobe held high. A design that cleared the flag early or recaptured on a level would report a wrong status byte.

// File: rtl/crtc_regbank_pkg.sv
package crtc_regbank_pkg;
  localparam int DW       = 8;
  localparam int NUM_REGS = 18;
  localparam int PTR_W    = 5;
  localparam int MA_W     = 14;
  localparam int LPEN_HI  = 16;
  localparam int LPEN_LO  = 17;
  localparam int FIRST_RD = 12;
  localparam int CFG_W    = NUM_REGS * DW;

  // implemented-bit mask for one register index
  function automatic logic [DW-1:0] impl_mask(input logic [PTR_W-1:0] idx);
    case (idx)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd13, 5'd15, 5'd17: impl_mask = 8'hFF;
      5'd4, 5'd6, 5'd7, 5'd10:                     impl_mask = 8'h7F;
      5'd5, 5'd9, 5'd11:                           impl_mask = 8'h1F;
      5'd8:                                        impl_mask = 8'h03;
      5'd12, 5'd14, 5'd16:                         impl_mask = 8'h3F;
      default:                                     impl_mask = 8'h00;
    endcase
  endfunction

  function automatic logic host_can_write(input logic [PTR_W-1:0] idx);
    return idx < PTR_W'(LPEN_HI);
  endfunction

  function automatic logic host_can_read(input logic [PTR_W-1:0] idx);
    return (idx >= PTR_W'(FIRST_RD)) && (idx <= PTR_W'(LPEN_LO));
  endfunction

  function automatic logic [DW-1:0] status_byte(input logic flag, input logic blank);
    return {1'b1, flag, blank, 5'b00000};
  endfunction
endpackage

// File: rtl/crtc_ptr.sv
module crtc_ptr
  import crtc_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic [PTR_W-1:0] sel_val,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)         ptr <= '0;
    else if (sel_we) ptr <= sel_val;
  end

  // R1: pointer is held between select writes
  assert_ptr_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !sel_we |=> $stable(ptr));
endmodule

// File: rtl/crtc_cfg_file.sv
module crtc_cfg_file
  import crtc_regbank_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           data_we,
  input  logic [PTR_W-1:0]               ptr,
  input  logic [DW-1:0]                  wdata,
  input  logic                           lpen_load,
  input  logic [MA_W-1:0]                lpen_addr,
  output logic [NUM_REGS-1:0][DW-1:0]    regs
);
  logic wr_ok;
  assign wr_ok = data_we && host_can_write(ptr);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == LPEN_HI) begin : g_lhi
      always_ff @(posedge clk) begin
        if (rst)            regs[i] <= '0;
        else if (lpen_load) regs[i] <= DW'(lpen_addr[MA_W-1:DW]) & impl_mask(PTR_W'(i));
      end
    end else if (i == LPEN_LO) begin : g_llo
      always_ff @(posedge clk) begin
        if (rst)            regs[i] <= '0;
        else if (lpen_load) regs[i] <= lpen_addr[DW-1:0] & impl_mask(PTR_W'(i));
      end
    end else begin : g_host
      logic hit;
      assign hit = wr_ok && (ptr == PTR_W'(i));
      always_ff @(posedge clk) begin
        if (rst)      regs[i] <= '0;
        else if (hit) regs[i] <= wdata & impl_mask(PTR_W'(i));
      end
    end
  end

  // R3: locked or out-of-range writes leave the whole file unchanged
  assert_locked_write_R3: assert property (@(posedge clk) disable iff (rst)
    (data_we && !host_can_write(ptr) && !lpen_load) |=> $stable(regs));
  // R2: a permitted write is visible next cycle with unused bits cleared
  assert_masked_store_R2: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> ((regs[$past(ptr)] & ~impl_mask($past(ptr))) == '0));
endmodule

// File: rtl/crtc_lpen.sv
module crtc_lpen
  import crtc_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lpen_stb,
  input  logic             data_rd,
  input  logic [PTR_W-1:0] ptr,
  output logic             capture,
  output logic             flag
);
  logic stb_q, seen_hi, seen_lo, hi_n, lo_n, both_read;

  assign capture   = lpen_stb && !stb_q;
  assign hi_n      = seen_hi || (data_rd && ptr == PTR_W'(LPEN_HI));
  assign lo_n      = seen_lo || (data_rd && ptr == PTR_W'(LPEN_LO));
  assign both_read = hi_n && lo_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0; flag <= 1'b0; seen_hi <= 1'b0; seen_lo <= 1'b0;
    end else begin
      stb_q <= lpen_stb;
      if (capture) begin
        flag <= 1'b1; seen_hi <= 1'b0; seen_lo <= 1'b0;
      end else if (both_read) begin
        flag <= 1'b0; seen_hi <= 1'b0; seen_lo <= 1'b0;
      end else begin
        seen_hi <= hi_n; seen_lo <= lo_n;
      end
    end
  end

  // R6: a strobe edge always raises the flag
  assert_capture_sets_R6: assert property (@(posedge clk) disable iff (rst)
    capture |=> flag);
  // R7: the flag only falls right after a data-port read
  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(data_rd));
endmodule

// File: rtl/crtc_regbank.sv
module crtc_regbank
  import crtc_regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_we,
  input  logic               data_we,
  input  logic               status_rd,
  input  logic               data_rd,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic               lpen_stb,
  input  logic [13:0]        cur_addr,
  input  logic               blanking,
  output logic [CFG_W-1:0]   cfg_bus
);
  logic [PTR_W-1:0]            ptr;
  logic [NUM_REGS-1:0][DW-1:0] regs;
  logic                        capture, flag;
  logic [DW-1:0]               reg_view;

  crtc_ptr u_ptr (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_val(wdata[PTR_W-1:0]), .ptr(ptr)
  );

  crtc_lpen u_lpen (
    .clk(clk), .rst(rst), .lpen_stb(lpen_stb), .data_rd(data_rd), .ptr(ptr),
    .capture(capture), .flag(flag)
  );

  crtc_cfg_file u_cfg (
    .clk(clk), .rst(rst), .data_we(data_we), .ptr(ptr), .wdata(wdata),
    .lpen_load(capture), .lpen_addr(cur_addr), .regs(regs)
  );

  always_comb begin
    reg_view = '1;
    if (host_can_read(ptr)) reg_view = regs[ptr];
  end

  assign rdata   = status_rd ? status_byte(flag, blanking) : reg_view;
  assign cfg_bus = regs;

  // R4: unreadable selection returns all ones
  assert_unreadable_ff_R4: assert property (@(posedge clk) disable iff (rst)
    (!status_rd && !host_can_read(ptr)) |-> (rdata == 8'hFF));
  // R5: status byte fixed bits
  assert_status_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    status_rd |-> (rdata[7] && rdata[4:0] == 5'd0 && rdata[5] == blanking));
endmodule

// File: tb/tb_crtc_regbank.sv
module tb_crtc_regbank;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic sel_we = 0, data_we = 0, status_rd = 0, data_rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic lpen_stb = 0, blanking = 0;
  logic [13:0] cur_addr = 0;
  logic [143:0] cfg_bus;

  int checks = 0, fails = 0;
  logic done = 0;

  crtc_regbank dut (
    .clk(clk), .rst(rst), .sel_we(sel_we), .data_we(data_we), .status_rd(status_rd),
    .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .lpen_stb(lpen_stb),
    .cur_addr(cur_addr), .blanking(blanking), .cfg_bus(cfg_bus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench's own view of implemented widths
  function automatic int bits_of(input int r);
    if (r == 8) return 2;
    if (r == 5 || r == 9 || r == 11) return 5;
    if (r == 4 || r == 6 || r == 7 || r == 10) return 7;
    if (r == 12 || r == 14 || r == 16) return 6;
    return 8;
  endfunction
  function automatic logic [7:0] mask_of(input int r);
    return 8'((1 << bits_of(r)) - 1);
  endfunction

  task automatic check(input string req, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic do_sel(input logic [7:0] v); sel_we = 1; wdata = v; cyc(); sel_we = 0; endtask
  task automatic do_wr(input logic [7:0] v); data_we = 1; wdata = v; cyc(); data_we = 0; endtask
  task automatic peek(output logic [7:0] v); #1 v = rdata; endtask
  task automatic peek_status(output logic [7:0] v);
    status_rd = 1; #1 v = rdata; status_rd = 0;
  endtask
  task automatic rd_strobe(); data_rd = 1; cyc(); data_rd = 0; endtask
  task automatic pulse_pen(input logic [13:0] a);
    cur_addr = a; lpen_stb = 1; cyc(); lpen_stb = 0; cyc();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rst = 1; cyc(); cyc(); rst = 0;
    check("R9 cfg after reset", cfg_bus, '0);
    peek_status(v); check("R9 status after reset", v, 8'h80);
    peek(v); check("R9 ptr 0 reads FF", v, 8'hFF);
  endtask

  task automatic t_fill();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) begin
      do_sel(8'(i)); do_wr(8'hFF);
      check($sformatf("R2 R8 reg %0d mask", i), cfg_bus[8*i +: 8], mask_of(i));
      peek(v);
      check($sformatf("R4 read reg %0d", i), v, (i >= 12) ? mask_of(i) : 8'hFF);
    end
    do_sel(8); do_wr(8'hA5);
    check("R2 reg 8 low bits", cfg_bus[64 +: 8], 8'h01);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    logic [7:0] r12;
    r12 = cfg_bus[96 +: 8];
    do_sel(13); do_wr(8'h11);
    check("R1 first write", cfg_bus[104 +: 8], 8'h11);
    do_wr(8'h22);
    check("R1 repeat write same reg", cfg_bus[104 +: 8], 8'h22);
    check("R1 neighbour untouched", cfg_bus[96 +: 8], r12);
    do_sel(8'h2E); do_wr(8'hC7);
    check("R1 5-bit pointer to 14", cfg_bus[112 +: 8], 8'h07);
    peek(v); check("R1 read via truncated ptr", v, 8'h07);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    logic [143:0] snap;
    do_sel(16); do_wr(8'h55);
    check("R3 reg 16 not written", cfg_bus[128 +: 8], 8'h00);
    do_sel(17); do_wr(8'h55);
    check("R3 reg 17 not written", cfg_bus[136 +: 8], 8'h00);
    snap = cfg_bus;
    do_sel(20); do_wr(8'h3C);
    check("R3 out-of-range write no effect", cfg_bus, snap);
    peek(v); check("R4 ptr 20 reads FF", v, 8'hFF);
    do_sel(31); peek(v); check("R4 ptr 31 reads FF", v, 8'hFF);
  endtask

  task automatic t_status();
    logic [7:0] v;
    blanking = 1; peek_status(v); check("R5 status blanking", v, 8'hA0);
    blanking = 0; peek_status(v); check("R5 status active", v, 8'h80);
  endtask

  task automatic t_lpen();
    logic [7:0] v;
    pulse_pen(14'h2ABC);
    check("R6 reg 16 high addr", cfg_bus[128 +: 8], 8'h2A);
    check("R6 reg 17 low addr", cfg_bus[136 +: 8], 8'hBC);
    peek_status(v); check("R6 flag set", v, 8'hC0);
    cur_addr = 14'h1111; lpen_stb = 1; cyc(); cyc();
    cur_addr = 14'h0555; cyc();
    check("R6 level does not recapture", cfg_bus[136 +: 8], 8'h11);
    lpen_stb = 0; cyc();
    do_sel(16); peek(v); check("R4 R6 data read reg 16", v, 8'h11);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    pulse_pen(14'h0042);
    do_sel(16); rd_strobe(); rd_strobe();
    peek_status(v); check("R7 one reg read twice keeps flag", v, 8'hC0);
    do_sel(17); rd_strobe();
    peek_status(v); check("R7 both read clears flag", v, 8'h80);
    pulse_pen(14'h3FFF);
    do_sel(17); rd_strobe();
    peek_status(v); check("R7 after reg 17 only", v, 8'hC0);
    do_sel(16); rd_strobe();
    peek_status(v); check("R7 reverse order clears", v, 8'h80);
  endtask

  task automatic t_reset_again();
    logic [7:0] v;
    pulse_pen(14'h1234);
    rst = 1; cyc(); rst = 0;
    check("R9 reset clears file", cfg_bus, '0);
    peek_status(v); check("R9 reset clears flag", v, 8'h80);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_sticky();
    t_locked();
    t_status();
    t_lpen();
    t_clear();
    t_reset_again();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule